// File: doc/BRIEF.md
# Charge Phase Safety and Top-Off Timer

This block bounds how long a battery charge cycle may stay in each phase. A charger state machine supplies the current charge phase, and a slow time base supplies a one-cycle `tick` strobe. In the precharge and fast-charge phases the block counts ticks against a phase-dependent limit. When the limit is reached it latches a two-bit fault code that tells the charger to stop. While any input regulation loop, thermal regulation or a derated temperature zone is active, the count runs at half speed. This stretches the allowed time to match the reduced charge current.

After termination, a separate top-off stage can keep charging for a programmable extra period. It shows a flag while it counts and emits a one-cycle pulse when the period ends. Limits are written in minutes and scaled by the `TICKS_PER_MIN` parameter, so the same block works with any tick rate.

Top module: `chg_safety_timer`

## Requirements
- R1: After synchronous reset, `fault_code_o` is 00, and both `topoff_active_o` and `topoff_done_o` are 0.
- R2: With `phase_i` = 01 (precharge) and the timer enabled, `fault_code_o` becomes 11 on the edge of the 120·TICKS_PER_MIN-th counted tick and stays 00 before it.
- R3: With `phase_i` = 10 (fast charge), the limit is 600·TICKS_PER_MIN counted ticks when `cfg_fast_short_i` = 1, and 1200·TICKS_PER_MIN counted ticks when it is 0.
- R4: While `cfg_timer_en_i` = 0, the count is held at zero and `fault_code_o` reads 00 from the next cycle on, including a fault that was already latched.
- R5: When `cfg_slow_en_i` = 1 and any of `vin_reg_i`, `therm_reg_i`, `cool_zone_i` or `warm_zone_i` is high, only every second tick is counted, so each limit takes twice as many ticks.
- R6: The cool or warm zone does not slow the count when `zone_full_i` = 1, and no condition slows it when `cfg_slow_en_i` = 0.
- R7: A change of `phase_i` into 01 or 10 from any other value clears the count and the fault, including the step from precharge to fast charge.
- R8: A high cycle on `reg_reset_i` clears the safety count and the fault.
- R9: A latched fault holds 11 through phases 00 (not charging) and 11 (terminated) until R4, R7 or R8 clears it.
- R10: When `phase_i` enters 11 with `cfg_topoff_sel_i` ≠ 00, `topoff_active_o` rises on that edge. After sel·15·TICKS_PER_MIN further ticks it falls, and `topoff_done_o` is high for exactly that one cycle.
- R11: With `cfg_topoff_sel_i` = 00 the top-off stage never becomes active. Leaving phase 11 while it counts aborts it with no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe, one cycle per tick |
| phase_i | input | 2 | Charge phase: 00 idle, 01 precharge, 10 fast, 11 terminated |
| vin_reg_i | input | 1 | Input voltage or current regulation active |
| therm_reg_i | input | 1 | Thermal regulation active |
| cool_zone_i | input | 1 | Battery in cool temperature zone |
| warm_zone_i | input | 1 | Battery in warm temperature zone |
| zone_full_i | input | 1 | Current setting of the active zone is 100 percent |
| cfg_timer_en_i | input | 1 | Safety limit enable |
| cfg_fast_short_i | input | 1 | Fast-charge limit select: 1 short, 0 long |
| cfg_slow_en_i | input | 1 | Enable half-rate counting under derating |
| cfg_topoff_sel_i | input | 2 | Top-off length in 15-minute steps, 00 off |
| reg_reset_i | input | 1 | Restart pulse for the safety count |
| fault_code_o | output | 2 | 11 when the safety limit has expired, else 00 |
| topoff_active_o | output | 1 | Top-off stage counting |
| topoff_done_o | output | 1 | One-cycle pulse when the top-off period ends |

## Verification
The bench probes each limit one tick before and exactly at expiry. An off-by-one counter would fault early or late, and a design that picked the wrong limit for the select would miss by hundreds of ticks. In the half-rate cases the bench requires expiry at exactly twice the tick count. A design that ignored the full-current exemption would then expire late, and one that slowed on the wrong condition would expire early. The bench also counts through a precharge-to-fast transition and a reset pulse to confirm that the count restarts from zero rather than carrying over. The top-off checks use both the shortest and the longest setting, an abort and the disabled code, so a stuck active flag, a double done pulse or a pulse after an abort is caught.

// File: rtl/chg_timer_pkg.sv
package chg_timer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_PRE  = 2'b01,
        PH_FAST = 2'b10,
        PH_DONE = 2'b11
    } phase_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_TIMER = 2'b11
    } fault_e;

    localparam int unsigned PRE_LIMIT_MIN   = 120;
    localparam int unsigned FAST_SHORT_MIN  = 600;
    localparam int unsigned FAST_LONG_MIN   = 1200;
    localparam int unsigned TOPOFF_STEP_MIN = 15;
    localparam int unsigned TOPOFF_MAX_MIN  = 3 * TOPOFF_STEP_MIN;

    function automatic int unsigned safety_minutes(input phase_e ph, input logic fast_short);
        case (ph)
            PH_PRE:  return PRE_LIMIT_MIN;
            PH_FAST: return fast_short ? FAST_SHORT_MIN : FAST_LONG_MIN;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned topoff_minutes(input logic [1:0] sel);
        return {30'd0, sel} * TOPOFF_STEP_MIN;
    endfunction

    function automatic logic is_charging(input phase_e ph);
        return (ph == PH_PRE) || (ph == PH_FAST);
    endfunction

endpackage

// File: rtl/chg_rate_gate.sv
module chg_rate_gate
    import chg_timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic tick,
    input  logic slow_en,
    input  logic vin_reg,
    input  logic therm_reg,
    input  logic cool_zone,
    input  logic warm_zone,
    input  logic zone_full,
    output logic advance_o
);

    logic slowed;
    logic half_q;

    always_comb begin
        slowed    = slow_en & (vin_reg | therm_reg | ((cool_zone | warm_zone) & ~zone_full));
        advance_o = run & tick & (~slowed | half_q);
    end

    always_ff @(posedge clk) begin
        if (rst || clear || !slowed) begin
            half_q <= 1'b0;
        end else if (run && tick) begin
            half_q <= ~half_q;
        end
    end

    // R5: two slowed advances never fall on consecutive cycles
    p_slow_alternate_r5: assert property (@(posedge clk) disable iff (rst)
        (advance_o && slowed) |=> !(advance_o && slowed));

endmodule

// File: rtl/chg_safety_cnt.sv
module chg_safety_cnt
    import chg_timer_pkg::*;
#(
    parameter int unsigned TICKS_PER_MIN = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   restart,
    input  logic   enable,
    input  phase_e phase,
    input  logic   fast_short,
    input  logic   advance,
    output logic   run_o,
    output logic   fault_o
);

    localparam int unsigned SAFE_MAX = FAST_LONG_MIN * TICKS_PER_MIN;
    localparam int unsigned CW       = $clog2(SAFE_MAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] limit;
    logic          fault_q;

    always_comb begin
        limit   = CW'(safety_minutes(phase, fast_short) * TICKS_PER_MIN);
        run_o   = enable & is_charging(phase) & ~fault_q;
        cnt_inc = advance ? cnt_q + CW'(1) : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !enable) begin
            cnt_q   <= '0;
            fault_q <= 1'b0;
        end else if (run_o) begin
            cnt_q   <= cnt_inc;
            fault_q <= (cnt_inc >= limit);
        end
    end

    assign fault_o = fault_q;

    // R3: the count never passes the longest limit
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(SAFE_MAX));

    // R5: the count moves by one step or returns to zero
    p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CW'(1) || cnt_q == '0));

    // R8: a restart leaves the count at zero
    p_restart_zero_r8: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0 && !fault_q));

endmodule

// File: rtl/chg_topoff_cnt.sv
module chg_topoff_cnt
    import chg_timer_pkg::*;
#(
    parameter int unsigned TICKS_PER_MIN = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  phase_e     phase,
    input  logic       enter_done,
    input  logic [1:0] sel,
    input  logic       tick,
    output logic       active_o,
    output logic       done_o
);

    localparam int unsigned TOP_MAX = TOPOFF_MAX_MIN * TICKS_PER_MIN;
    localparam int unsigned TW      = $clog2(TOP_MAX + 1);

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] cnt_inc;
    logic [TW-1:0] limit;
    logic          active_q;
    logic          done_q;

    always_comb begin
        limit   = TW'(topoff_minutes(sel) * TICKS_PER_MIN);
        cnt_inc = cnt_q + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            cnt_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (phase != PH_DONE || sel == 2'b00) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else if (enter_done) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
            end else if (active_q && tick) begin
                if (cnt_inc >= limit) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_inc;
                end
            end
        end
    end

    assign active_o = active_q;
    assign done_o   = done_q;

    // R10: the done strobe lasts one cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R10: done and active never coincide
    p_done_not_active_r10: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !active_q);

    // R11: active only follows a terminated phase
    p_active_needs_done_r11: assert property (@(posedge clk) disable iff (rst)
        active_q |-> ($past(phase) == PH_DONE));

endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer
    import chg_timer_pkg::*;
#(
    parameter int unsigned TICKS_PER_MIN = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] phase_i,
    input  logic       vin_reg_i,
    input  logic       therm_reg_i,
    input  logic       cool_zone_i,
    input  logic       warm_zone_i,
    input  logic       zone_full_i,
    input  logic       cfg_timer_en_i,
    input  logic       cfg_fast_short_i,
    input  logic       cfg_slow_en_i,
    input  logic [1:0] cfg_topoff_sel_i,
    input  logic       reg_reset_i,
    output logic [1:0] fault_code_o,
    output logic       topoff_active_o,
    output logic       topoff_done_o
);

    phase_e phase;
    phase_e prev_q;
    logic   enter_run;
    logic   enter_done;
    logic   restart;
    logic   run;
    logic   advance;
    logic   fault;
    fault_e code;

    always_comb begin
        phase      = phase_e'(phase_i);
        enter_run  = (phase != prev_q) && is_charging(phase);
        enter_done = (phase == PH_DONE) && (prev_q != PH_DONE);
        restart    = enter_run | reg_reset_i;
        code       = fault ? FLT_TIMER : FLT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= PH_IDLE;
        else     prev_q <= phase;
    end

    chg_rate_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .clear     (restart | ~cfg_timer_en_i),
        .run       (run),
        .tick      (tick),
        .slow_en   (cfg_slow_en_i),
        .vin_reg   (vin_reg_i),
        .therm_reg (therm_reg_i),
        .cool_zone (cool_zone_i),
        .warm_zone (warm_zone_i),
        .zone_full (zone_full_i),
        .advance_o (advance)
    );

    chg_safety_cnt #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_safety (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .enable     (cfg_timer_en_i),
        .phase      (phase),
        .fast_short (cfg_fast_short_i),
        .advance    (advance),
        .run_o      (run),
        .fault_o    (fault)
    );

    chg_topoff_cnt #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_topoff (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .enter_done (enter_done),
        .sel        (cfg_topoff_sel_i),
        .tick       (tick),
        .active_o   (topoff_active_o),
        .done_o     (topoff_done_o)
    );

    assign fault_code_o = code;

    // R4: disabling the limits clears the fault on the next edge
    p_off_clears_fault_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_timer_en_i |=> (fault_code_o == 2'b00));

    // R7: entering a charging phase clears the fault
    p_entry_clears_fault_r7: assert property (@(posedge clk) disable iff (rst)
        enter_run |=> (fault_code_o == 2'b00));

    // R9: a fault holds while nothing clears it
    p_fault_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (fault_code_o == 2'b11 && cfg_timer_en_i && !restart) |=> (fault_code_o == 2'b11));

endmodule

// File: tb/chg_safety_timer_test.sv
module chg_safety_timer_test;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] phase = 2'b00;
    logic       vin_reg = 1'b0, therm_reg = 1'b0, cool = 1'b0, warm = 1'b0, zfull = 1'b0;
    logic       en = 1'b1, fshort = 1'b1, slow_en = 1'b1;
    logic [1:0] tsel = 2'b00;
    logic       rreset = 1'b0;
    logic [1:0] fault;
    logic       tactive, tdone;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chg_safety_timer uut (
        .clk(clk), .rst(rst), .tick(tick), .phase_i(phase),
        .vin_reg_i(vin_reg), .therm_reg_i(therm_reg), .cool_zone_i(cool),
        .warm_zone_i(warm), .zone_full_i(zfull), .cfg_timer_en_i(en),
        .cfg_fast_short_i(fshort), .cfg_slow_en_i(slow_en),
        .cfg_topoff_sel_i(tsel), .reg_reset_i(rreset),
        .fault_code_o(fault), .topoff_active_o(tactive), .topoff_done_o(tdone)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic go_phase(input logic [1:0] p);
        phase = p;
        tick  = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic clear_conds();
        vin_reg = 0; therm_reg = 0; cool = 0; warm = 0; zfull = 0;
        en = 1; fshort = 1; slow_en = 1; tsel = 2'b00;
        go_phase(2'b00);
    endtask

    task automatic expiry(input string req, input logic [1:0] p, input int n);
        go_phase(p);
        ticks(n - 1);
        chk(req, "one tick before limit", fault, 0);
        ticks(1);
        chk(req, "at limit", fault, 3);
    endtask

    task automatic t_reset();
        chk("R1", "fault after reset", fault, 0);
        chk("R1", "topoff active after reset", tactive, 0);
        chk("R1", "topoff done after reset", tdone, 0);
    endtask

    task automatic t_precharge();
        clear_conds();
        expiry("R2", 2'b01, 120);
    endtask

    task automatic t_fast();
        clear_conds();
        expiry("R3", 2'b10, 600);
        clear_conds();
        fshort = 0;
        expiry("R3", 2'b10, 1200);
    endtask

    task automatic t_disable();
        clear_conds();
        en = 0;
        go_phase(2'b01);
        ticks(200);
        chk("R4", "no fault while disabled", fault, 0);
        en = 1;
        ticks(119);
        chk("R4", "count restarted from zero", fault, 0);
        ticks(1);
        chk("R4", "expires after re-enable", fault, 3);
        en = 0;
        @(negedge clk);
        chk("R4", "latched fault cleared", fault, 0);
    endtask

    task automatic t_slow();
        clear_conds();
        vin_reg = 1;
        expiry("R5", 2'b01, 240);
        clear_conds();
        therm_reg = 1;
        fshort = 0;
        expiry("R5", 2'b10, 2400);
        clear_conds();
        warm = 1;
        expiry("R5", 2'b01, 240);
    endtask

    task automatic t_zone_full();
        clear_conds();
        cool = 1; zfull = 1;
        expiry("R6", 2'b01, 120);
        clear_conds();
        slow_en = 0; vin_reg = 1; warm = 1;
        expiry("R6", 2'b01, 120);
    endtask

    task automatic t_restart();
        clear_conds();
        go_phase(2'b01);
        ticks(100);
        go_phase(2'b10);
        ticks(599);
        chk("R7", "pre to fast restarted count", fault, 0);
        ticks(1);
        chk("R7", "fast limit after restart", fault, 3);
        go_phase(2'b01);
        chk("R7", "entry clears fault", fault, 0);
    endtask

    task automatic t_regreset();
        clear_conds();
        go_phase(2'b10);
        ticks(100);
        rreset = 1; @(negedge clk); rreset = 0;
        ticks(599);
        chk("R8", "count restarted by pulse", fault, 0);
        ticks(1);
        chk("R8", "expiry after pulse", fault, 3);
        rreset = 1; @(negedge clk); rreset = 0;
        chk("R8", "pulse clears fault", fault, 0);
    endtask

    task automatic t_hold();
        clear_conds();
        expiry("R9", 2'b01, 120);
        go_phase(2'b00);
        ticks(10);
        chk("R9", "fault held in idle", fault, 3);
        go_phase(2'b11);
        chk("R9", "fault held in terminated", fault, 3);
    endtask

    task automatic t_topoff();
        clear_conds();
        tsel = 2'b01;
        go_phase(2'b10);
        go_phase(2'b11);
        chk("R10", "active on entry", tactive, 1);
        ticks(14);
        chk("R10", "still active before end", tactive, 1);
        chk("R10", "no early done", tdone, 0);
        ticks(1);
        chk("R10", "done pulse", tdone, 1);
        chk("R10", "inactive at end", tactive, 0);
        @(negedge clk);
        chk("R10", "done lasts one cycle", tdone, 0);
        tsel = 2'b11;
        go_phase(2'b10);
        go_phase(2'b11);
        ticks(44);
        chk("R10", "45 min still active", tactive, 1);
        ticks(1);
        chk("R10", "45 min done", tdone, 1);
    endtask

    task automatic t_topoff_off();
        int seen;
        clear_conds();
        tsel = 2'b00;
        go_phase(2'b10);
        go_phase(2'b11);
        chk("R11", "disabled top-off inactive", tactive, 0);
        seen = 0;
        tick = 1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            seen += tdone + tactive;
        end
        tick = 0;
        chk("R11", "disabled top-off silent", seen, 0);
        tsel = 2'b01;
        go_phase(2'b10);
        go_phase(2'b11);
        ticks(5);
        go_phase(2'b00);
        chk("R11", "abort clears active", tactive, 0);
        seen = 0;
        tick = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            seen += tdone;
        end
        tick = 0;
        chk("R11", "no done after abort", seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_precharge();
        t_fast();
        t_disable();
        t_slow();
        t_zone_full();
        t_restart();
        t_regreset();
        t_hold();
        t_topoff();
        t_topoff_off();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule